// File: doc/BRIEF.md
# NAND ECC Control Register

This block is a single 32-bit memory-mapped control register for an external NAND flash controller that serves up to four chip selects. Software uses it to mark which chip selects carry NAND devices and to pick the chip select that the 4-bit ECC engine works on. It also uses it to launch the ECC engines through start flags. The start flags are write-one-to-set. Writing zero to them does nothing. Each flag drops by itself when software later reads the matching result register elsewhere in the controller.

Those result-register reads reach this block as a one-hot group of strobes. There is one strobe per chip select for the 1-bit ECC results, one strobe for any 4-bit ECC result read, and one strobe for any error-location read. The flag and field values are driven as levels to the ECC engines. Register reads return data one cycle after the read request.

Top module: `nfc_ecc_ctl`

## Requirements
- R1: After reset, every output is 0, and a read of the register returns 0.
- R2: Bits 31 to 14 and bits 7 to 6 always read as 0, and writing 1 to them has no effect.
- R3: Bits 3 to 0 (NAND-use flag of chip select i at bit i) and bits 5 to 4 (4-bit ECC chip-select selector) are plain read/write fields. A write updates them on the next cycle.
- R4: Writing 1 to bit 13 sets the error-location start flag. Writing 0 to it leaves the flag unchanged.
- R5: The error-location start flag clears when strobe bit 5 (error-location result read) is high.
- R6: Writing 1 to bit 12 sets the 4-bit ECC start flag, and writing 0 leaves it unchanged. The flag clears when strobe bit 4 (4-bit ECC result read) is high.
- R7: Writing 1 to bit 8+i sets the 1-bit ECC start flag of chip select i, and writing 0 leaves it unchanged.
- R8: The 1-bit ECC start flag of chip select i clears only when strobe bit i is high. Strobes for other chip selects leave it set.
- R9: When a write sets a flag in the same cycle as a strobe that clears that flag, the flag ends up set.
- R10: A read returns, one cycle later, the register value from before any clear that happens in the read cycle.
- R11: Writes to any other address change nothing, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr_en | input | 1 | Write request |
| bus_wdata | input | DATA_W | Write data |
| bus_rd_en | input | 1 | Read request |
| bus_rdata | output | DATA_W | Read data, valid one cycle after the read request |
| rslt_rd_strb | input | NUM_CS+2 | One-hot result-read strobes: 1-bit per chip select, 4-bit result, error location |
| cs_nand_en | output | NUM_CS | NAND-use flag per chip select |
| ecc4_cs_sel | output | 2 | Chip select used by the 4-bit ECC |
| ecc1_go | output | NUM_CS | 1-bit ECC start flags |
| ecc4_go | output | 1 | 4-bit ECC start flag |
| errloc_go | output | 1 | Error address/value calculation start flag |

## Verification
The assertions assume that at most one result-read strobe is high in any cycle. They also assume that the bus inputs are driven to known values from reset onward, and one of them checks the strobe assumption. The stimulus changes inputs only on the falling clock edge and raises a single strobe at a time. Collisions of a set with a clear, and of a read with a clear, are built from that single strobe together with a write or a read in the same cycle.

// File: rtl/nfc_ecc_pkg.sv
`timescale 1ns/1ps
package nfc_ecc_pkg;
   localparam int MAX_CS      = 4;
   localparam int SEL_W       = 2;
   localparam int USE_LSB     = 0;
   localparam int SEL_LSB     = 4;
   localparam int ECC1_LSB    = 8;
   localparam int ECC4_BIT    = 12;
   localparam int ERRLOC_BIT  = 13;
   localparam int USED_MSB    = 13;
endpackage

// File: rtl/nfc_w1s_flag.sv
`timescale 1ns/1ps
module nfc_w1s_flag #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= RST_VAL;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   // R8
   clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
   // R4, R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/nfc_rw_field.sv
`timescale 1ns/1ps
module nfc_rw_field #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (W < 1) begin : g_bad_w
      $error("nfc_rw_field: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (we_i) q_o <= d_i;
   end

   // R3
   rw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(q_o));
endmodule

// File: rtl/nfc_rd_port.sv
`timescale 1ns/1ps
module nfc_rd_port #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en_i,
   input  logic          hit_i,
   input  logic [DW-1:0] val_i,
   output logic [DW-1:0] rdata_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 rdata_o <= '0;
      else if (rd_en_i && hit_i)  rdata_o <= val_i;
      else                        rdata_o <= '0;
   end

   // R11
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en_i && hit_i) |=> (rdata_o == '0));
endmodule

// File: rtl/nfc_ecc_ctl.sv
`timescale 1ns/1ps
module nfc_ecc_ctl
   import nfc_ecc_pkg::*;
#(
   parameter int               ADDR_W   = 8,
   parameter int               DATA_W   = 32,
   parameter int               NUM_CS   = 4,
   parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h60
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr_en,
   input  logic [DATA_W-1:0]   bus_wdata,
   input  logic                bus_rd_en,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_CS+1:0]   rslt_rd_strb,
   output logic [NUM_CS-1:0]   cs_nand_en,
   output logic [SEL_W-1:0]    ecc4_cs_sel,
   output logic [NUM_CS-1:0]   ecc1_go,
   output logic                ecc4_go,
   output logic                errloc_go
);
   localparam int STRB_W  = NUM_CS + 2;
   localparam int STRB_E4 = NUM_CS;
   localparam int STRB_EL = NUM_CS + 1;

   if (NUM_CS < 1 || NUM_CS > MAX_CS) begin : g_bad_cs
      $error("nfc_ecc_ctl: NUM_CS must be 1 to 4");
   end
   if (DATA_W <= USED_MSB) begin : g_bad_dw
      $error("nfc_ecc_ctl: DATA_W too narrow for the field layout");
   end

   logic              wr_hit;
   logic              rd_hit;
   logic [DATA_W-1:0] reg_val;
   logic [DATA_W-1:0] rsv_mask;

   assign wr_hit = bus_wr_en && (bus_addr == CTL_ADDR);
   assign rd_hit = (bus_addr == CTL_ADDR);

   nfc_rw_field #(.W(NUM_CS)) u_use (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (wr_hit),
      .d_i   (bus_wdata[USE_LSB +: NUM_CS]),
      .q_o   (cs_nand_en)
   );

   nfc_rw_field #(.W(SEL_W)) u_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (wr_hit),
      .d_i   (bus_wdata[SEL_LSB +: SEL_W]),
      .q_o   (ecc4_cs_sel)
   );

   for (genvar i = 0; i < NUM_CS; i++) begin : g_ecc1
      nfc_w1s_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (wr_hit && bus_wdata[ECC1_LSB + i]),
         .clr_i (rslt_rd_strb[i]),
         .q_o   (ecc1_go[i])
      );
   end

   nfc_w1s_flag u_ecc4 (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (wr_hit && bus_wdata[ECC4_BIT]),
      .clr_i (rslt_rd_strb[STRB_E4]),
      .q_o   (ecc4_go)
   );

   nfc_w1s_flag u_errloc (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (wr_hit && bus_wdata[ERRLOC_BIT]),
      .clr_i (rslt_rd_strb[STRB_EL]),
      .q_o   (errloc_go)
   );

   always_comb begin
      reg_val = '0;
      reg_val[USE_LSB +: NUM_CS]  = cs_nand_en;
      reg_val[SEL_LSB +: SEL_W]   = ecc4_cs_sel;
      reg_val[ECC1_LSB +: NUM_CS] = ecc1_go;
      reg_val[ECC4_BIT]           = ecc4_go;
      reg_val[ERRLOC_BIT]         = errloc_go;
   end

   always_comb begin
      rsv_mask = '1;
      rsv_mask[USE_LSB +: NUM_CS]  = '0;
      rsv_mask[SEL_LSB +: SEL_W]   = '0;
      rsv_mask[ECC1_LSB +: NUM_CS] = '0;
      rsv_mask[ECC4_BIT]           = 1'b0;
      rsv_mask[ERRLOC_BIT]         = 1'b0;
   end

   nfc_rd_port #(.DW(DATA_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en_i (bus_rd_en),
      .hit_i   (rd_hit),
      .val_i   (reg_val),
      .rdata_o (bus_rdata)
   );

   // R8
   strb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rslt_rd_strb));
   // R2
   rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata & rsv_mask) == '0);
   // R1
   rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (cs_nand_en == '0 && ecc1_go == '0 && !ecc4_go
                         && !errloc_go && ecc4_cs_sel == '0));
   // R10
   pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_en && rd_hit && rslt_rd_strb[STRB_E4] && ecc4_go
       && !(wr_hit && bus_wdata[ECC4_BIT]))
      |=> (bus_rdata[ECC4_BIT] && !ecc4_go));

   logic [STRB_W-1:0] unused_w;
   assign unused_w = rslt_rd_strb;
endmodule

// File: tb/nfc_ecc_ctl_bench.sv
`timescale 1ns/1ps
module nfc_ecc_ctl_bench;
   localparam logic [7:0] CA = 8'h60;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  addr;
   logic        wr_en, rd_en;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic [5:0]  strb;
   logic [3:0]  use_o, e1_o;
   logic [1:0]  sel_o;
   logic        e4_o, el_o;

   always #2.5 clk = ~clk;

   nfc_ecc_ctl u_nfc_ecc_ctl (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr_en(wr_en),
      .bus_wdata(wdata), .bus_rd_en(rd_en), .bus_rdata(rdata),
      .rslt_rd_strb(strb), .cs_nand_en(use_o), .ecc4_cs_sel(sel_o),
      .ecc1_go(e1_o), .ecc4_go(e4_o), .errloc_go(el_o)
   );

   int nchk = 0, nfail = 0;
   bit run = 0, done = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   logic [3:0] m_use = '0, m_e1 = '0;
   logic [1:0] m_sel = '0;
   logic       m_e4 = 0, m_el = 0;

   function automatic logic [31:0] mval();
      return {18'd0, m_el, m_e4, m_e1, 2'b00, m_sel, m_use};
   endfunction

   task automatic chk(string tg, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h", tg, act, exp);
      end
   endtask

   task automatic cyc(bit w, bit r, logic [7:0] a, logic [31:0] d,
                      logic [5:0] c, string tg);
      @(negedge clk);
      wr_en = w; rd_en = r; addr = a; wdata = d; strb = c;
      if (r) begin
         exp_q.push_back((a == CA) ? mval() : 32'd0);
         tag_q.push_back(tg);
      end
      @(posedge clk);
      for (int i = 0; i < 4; i++) if (c[i]) m_e1[i] = 1'b0;
      if (c[4]) m_e4 = 1'b0;
      if (c[5]) m_el = 1'b0;
      if (w && a == CA) begin
         m_use = d[3:0];
         m_sel = d[5:4];
         m_e1  = m_e1 | d[11:8];
         if (d[12]) m_e4 = 1'b1;
         if (d[13]) m_el = 1'b1;
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 32'd0, 6'd0, "idle");
   endtask

   // monitor: compares outputs with the model and pops expected read data
   always @(posedge clk) begin
      #1;
      if (rst_n && run) begin
         chk("R3 use", {28'd0, use_o}, {28'd0, m_use});
         chk("R3 sel", {30'd0, sel_o}, {30'd0, m_sel});
         chk("R8 ecc1", {28'd0, e1_o}, {28'd0, m_e1});
         chk("R6 ecc4", {31'd0, e4_o}, {31'd0, m_e4});
         chk("R5 errloc", {31'd0, el_o}, {31'd0, m_el});
         if (exp_q.size() > 0) chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL R1 watchdog act=running exp=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin
      rst_n = 0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0; strb = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1: outputs during and right after reset
      chk("R1 outs", {18'd0, el_o, e4_o, e1_o, 2'b00, sel_o, use_o}, 32'd0);
      chk("R1 rdata", rdata, 32'd0);
      @(negedge clk); rst_n = 1;
      run = 1;
      cyc(0, 1, CA, 32'd0, 6'd0, "R1 read after reset");
      // R2: all ones, reserved bits must read back 0
      cyc(1, 0, CA, 32'hFFFF_FFFF, 6'd0, "R2 write");
      cyc(0, 1, CA, 32'd0, 6'd0, "R2 readback");
      chk("R2 pattern", mval(), 32'h0000_3F3F);
      // R4 R7: zero write leaves flags, clears RW fields (R3)
      cyc(1, 0, CA, 32'd0, 6'd0, "R4 zero write");
      cyc(0, 1, CA, 32'd0, 6'd0, "R7 flags kept");
      // R8: clear chip select 0 only, then 2
      cyc(0, 0, CA, 32'd0, 6'b000001, "R8 clr cs0");
      cyc(0, 1, CA, 32'd0, 6'd0, "R8 after cs0");
      cyc(0, 0, CA, 32'd0, 6'b000100, "R8 clr cs2");
      // R6, R5
      cyc(0, 0, CA, 32'd0, 6'b010000, "R6 clr");
      cyc(0, 1, CA, 32'd0, 6'd0, "R6 after");
      cyc(0, 0, CA, 32'd0, 6'b100000, "R5 clr");
      cyc(0, 1, CA, 32'd0, 6'd0, "R5 after");
      // R9: set and clear together
      cyc(1, 0, CA, 32'h0000_0100, 6'b000001, "R9 ecc1");
      cyc(1, 0, CA, 32'h0000_1000, 6'b010000, "R9 ecc4");
      cyc(1, 0, CA, 32'h0000_2000, 6'b100000, "R9 errloc");
      cyc(0, 1, CA, 32'd0, 6'd0, "R9 readback");
      // R10: read in the same cycle as a clear returns pre-clear data
      cyc(0, 1, CA, 32'd0, 6'b010000, "R10 ecc4");
      cyc(0, 1, CA, 32'd0, 6'b000001, "R10 ecc1");
      cyc(0, 1, CA, 32'd0, 6'd0, "R10 after");
      // R11: other addresses
      cyc(1, 0, 8'h64, 32'h0000_3F3F, 6'd0, "R11 write miss");
      cyc(0, 1, 8'h64, 32'd0, 6'd0, "R11 read miss");
      cyc(0, 1, CA, 32'd0, 6'd0, "R11 unchanged");
      // R3: selector and use patterns
      for (int k = 0; k < 4; k++) begin
         cyc(1, 0, CA, {26'd0, k[1:0], 4'(4'b0101 << k)}, 6'd0, "R3 write");
         cyc(0, 1, CA, 32'd0, 6'd0, "R3 readback");
      end
      // R7: single chip-select starts one at a time
      for (int k = 0; k < 4; k++) begin
         cyc(1, 0, CA, 32'h100 << k, 6'd0, "R7 set");
         cyc(0, 1, CA, 32'd0, 6'(1 << k), "R7 read+clr");
      end
      idle(3);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule